// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block is a hardware master that loads a configuration image into a downstream FPGA through its 8-bit slave parallel port. After a start pulse it runs the whole sequence. It pulses the program line low and waits for the target to report that its memory is clearing. It then releases the program line and waits for the target to report ready. It selects the port for writing and pauses for a set time. It then clocks the image in one byte per configuration clock cycle. At the end it checks that the target reports completion.

The host supplies the total image length together with the start pulse. It then streams the bytes over a valid/ready handshake. A byte is taken only while the port is selected and the target is ready for the next byte. If the host stalls, the block waits with the configuration clock held high, so no byte is dropped or sent twice.

Each waiting phase has its own timeout, counted in system clock cycles. Every failure ends the same way: the port is deselected, the data bus is released, and a failure flag is raised together with a code naming the cause.

Top module: `cfg_loader`

## Requirements
- R1: After reset, prog_n_o, cclk_o, csel_n_o and wr_n_o are high, cdata_oe_o is low, and active_o, ok_o, fail_o and byte_ready_o are low.
- R2: A start pulse drives prog_n_o low for at least PROG_CYC cycles. prog_n_o stays low until tgt_init_n_i is seen low. If tgt_init_n_i does not go low within INIT_TMO cycles, the load fails with code 1.
- R3: Once prog_n_o is high again, the block waits for tgt_init_n_i high and tgt_busy_i low at the same time. If that does not happen within INIT_TMO cycles, the load fails with code 2.
- R4: csel_n_o and wr_n_o go low together. At least SETTLE_CYC cycles then pass before the first falling edge of cclk_o.
- R5: Each byte is presented on cdata_o with cdata_oe_o high. cclk_o then stays low for at least CCLK_LO cycles and high for at least CCLK_HI cycles, and cdata_o is stable at the rising edge. Host bytes reach the target in order, each exactly once, under any pattern of byte_valid_i gaps. byte_ready_o is high only while the port is selected.
- R6: With CHECK_BUSY=1, no new byte is clocked while tgt_busy_i is high after a byte. If tgt_busy_i stays high for BUSY_TMO cycles, the load fails with code 4.
- R7: If tgt_done_i is high before a byte is sent, the block stops taking bytes, even when some remain, and goes on to the final check.
- R8: If tgt_init_n_i is low before a byte is sent and tgt_done_i is low, the load aborts with code 3 and no further byte is clocked.
- R9: After the last byte, csel_n_o rises at least one cycle before wr_n_o. ok_o is raised only when tgt_done_i and tgt_init_n_i are both high. If that does not happen within DONE_TMO cycles, the load fails with code 5.
- R10: On any failure, the block raises fail_o with a nonzero fail_code_o, sets csel_n_o, wr_n_o and prog_n_o high, and drives cdata_oe_o low. A new start clears ok_o and fail_o and runs the sequence again from the program pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| total_bytes_i | input | CNT_W | Number of image bytes, sampled with start |
| byte_data_i | input | DW | Host image byte |
| byte_valid_i | input | 1 | Host byte valid |
| byte_ready_o | output | 1 | Block takes the byte this cycle if valid |
| prog_n_o | output | 1 | Program line to target, active low |
| cclk_o | output | 1 | Configuration clock to target |
| csel_n_o | output | 1 | Port select to target, active low |
| wr_n_o | output | 1 | Write direction to target, active low |
| cdata_o | output | DW | Configuration data byte |
| cdata_oe_o | output | 1 | Output enable for the data bus |
| tgt_init_n_i | input | 1 | Target init/error line, active low |
| tgt_busy_i | input | 1 | Target busy line |
| tgt_done_i | input | 1 | Target completion line |
| active_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Last sequence succeeded (held until next start) |
| fail_o | output | 1 | Last sequence failed (held until next start) |
| fail_code_o | output | 3 | Failure cause: 1 init-assert, 2 init-release, 3 CRC, 4 busy, 5 done |

## Verification
The bench builds the block with every timeout shrunk to a few dozen cycles: a 4-cycle program pulse, a 20-cycle init timeout, a 12-cycle busy timeout, a 30-cycle final timeout and a 3-cycle settle pause. The clock low and high times are 2 cycles each, and busy checking is enabled. With these values, all five failure codes can be reached in a short run. A behavioural target on the other side can hold its lines at will, and the host stream can be made to stall between bytes.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PROG, ST_WAIT_ILO, ST_WAIT_IHI, ST_SETTLE, ST_CHECK,
    ST_CLK_LO, ST_CLK_HI, ST_BUSY_WAIT, ST_CS_OFF, ST_FINAL
  } st_e;

  typedef enum logic [2:0] {
    FC_NONE         = 3'd0,
    FC_INIT_ASSERT  = 3'd1,
    FC_INIT_RELEASE = 3'd2,
    FC_CRC          = 3'd3,
    FC_BUSY         = 3'd4,
    FC_DONE         = 3'd5
  } fail_e;

  // cycle budget of the phase the sequencer is in
  function automatic logic [31:0] phase_limit(
    st_e s, logic [31:0] prog, logic [31:0] init, logic [31:0] settle,
    logic [31:0] lo, logic [31:0] hi, logic [31:0] busy, logic [31:0] done);
    case (s)
      ST_PROG:                  return prog;
      ST_WAIT_ILO, ST_WAIT_IHI: return init;
      ST_SETTLE:                return settle;
      ST_CLK_LO:                return lo;
      ST_CLK_HI:                return hi;
      ST_BUSY_WAIT:             return busy;
      ST_FINAL:                 return done;
      default:                  return 32'd1;
    endcase
  endfunction

  // port selected for writing
  function automatic logic port_selected(st_e s);
    return (s == ST_SETTLE) || (s == ST_CHECK) || (s == ST_CLK_LO) ||
           (s == ST_CLK_HI) || (s == ST_BUSY_WAIT);
  endfunction

  // a phase whose count has used up its budget
  function automatic logic budget_spent(logic [31:0] cnt, logic [31:0] limit);
    return (limit == 32'd0) || (cnt >= limit - 32'd1);
  endfunction

endpackage

// File: rtl/cfgld_timer.sv
module cfgld_timer
  import cfgld_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);

  logic [TW-1:0] cnt_q;

  assign expired_o = budget_spent(32'(cnt_q), 32'(limit_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  // R2: the phase counter never runs past its budget
  a_r2_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i != '0) |-> (cnt_q < limit_i));

endmodule

// File: rtl/cfgld_bytecnt.sv
module cfgld_bytecnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             empty_o
);

  logic [CNT_W-1:0] left_q;

  assign empty_o = (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left_q <= '0;
    else if (load_i) left_q <= load_val_i;
    else if (dec_i)  left_q <= left_q - 1'b1;
  end

  // R5: a byte is never taken once the image is used up
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> !empty_o);

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int DW         = 8,
  parameter int TW         = 32,
  parameter int PROG_CYC   = 64,
  parameter int INIT_TMO   = 100_000_000,
  parameter int SETTLE_CYC = 2_000_000,
  parameter int CCLK_LO    = 2,
  parameter int CCLK_HI    = 2,
  parameter int BUSY_TMO   = 1_000_000,
  parameter int DONE_TMO   = 40_000_000,
  parameter bit CHECK_BUSY = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] byte_data_i,
  input  logic          byte_valid_i,
  input  logic          init_n_i,
  input  logic          tbusy_i,
  input  logic          done_i,
  input  logic          expired_i,
  input  logic          empty_i,
  output logic          clr_o,
  output logic [TW-1:0] limit_o,
  output logic          accept_o,
  output logic          load_o,
  output logic          byte_ready_o,
  output logic          prog_n_o,
  output logic          cclk_o,
  output logic          csel_n_o,
  output logic          wr_n_o,
  output logic [DW-1:0] cdata_o,
  output logic          cdata_oe_o,
  output logic          active_o,
  output logic          ok_o,
  output logic          fail_o,
  output logic [2:0]    fail_code_o
);

  st_e           state_q, state_d;
  logic [DW-1:0] data_q;
  logic          ok_q, fail_q;
  fail_e         code_q;

  // named internal events
  logic  ev_fail, ev_ok, ev_take_ok;
  fail_e ev_code;

  assign ev_take_ok   = (state_q == ST_CHECK) && !empty_i && !done_i && init_n_i;
  assign byte_ready_o = ev_take_ok;
  assign accept_o     = ev_take_ok && byte_valid_i;
  assign load_o       = (state_q == ST_IDLE) && start_i;
  assign clr_o        = (state_d != state_q);
  assign limit_o      = TW'(phase_limit(state_q, 32'(PROG_CYC), 32'(INIT_TMO),
                          32'(SETTLE_CYC), 32'(CCLK_LO), 32'(CCLK_HI),
                          32'(BUSY_TMO), 32'(DONE_TMO)));

  always_comb begin
    state_d = state_q;
    ev_fail = 1'b0;
    ev_ok   = 1'b0;
    ev_code = FC_NONE;
    case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_PROG;
      ST_PROG:      if (expired_i) state_d = ST_WAIT_ILO;
      ST_WAIT_ILO: begin
        if (!init_n_i)      state_d = ST_WAIT_IHI;
        else if (expired_i) begin ev_fail = 1'b1; ev_code = FC_INIT_ASSERT; end
      end
      ST_WAIT_IHI: begin
        if (init_n_i && !tbusy_i) state_d = ST_SETTLE;
        else if (expired_i)       begin ev_fail = 1'b1; ev_code = FC_INIT_RELEASE; end
      end
      ST_SETTLE:    if (expired_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (empty_i || done_i) state_d = ST_CS_OFF;
        else if (!init_n_i)    begin ev_fail = 1'b1; ev_code = FC_CRC; end
        else if (byte_valid_i) state_d = ST_CLK_LO;
      end
      ST_CLK_LO:    if (expired_i) state_d = ST_CLK_HI;
      ST_CLK_HI:    if (expired_i) state_d = CHECK_BUSY ? ST_BUSY_WAIT : ST_CHECK;
      ST_BUSY_WAIT: begin
        if (!tbusy_i)       state_d = ST_CHECK;
        else if (expired_i) begin ev_fail = 1'b1; ev_code = FC_BUSY; end
      end
      ST_CS_OFF:    state_d = ST_FINAL;
      ST_FINAL: begin
        if (done_i && init_n_i) begin ev_ok = 1'b1; state_d = ST_IDLE; end
        else if (expired_i)     begin ev_fail = 1'b1; ev_code = FC_DONE; end
      end
      default:      state_d = ST_IDLE;
    endcase
    if (ev_fail) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
      code_q  <= FC_NONE;
    end else begin
      state_q <= state_d;
      if (accept_o) data_q <= byte_data_i;
      if (load_o) begin
        ok_q   <= 1'b0;
        fail_q <= 1'b0;
        code_q <= FC_NONE;
      end else if (ev_fail) begin
        fail_q <= 1'b1;
        code_q <= ev_code;
      end else if (ev_ok) begin
        ok_q <= 1'b1;
      end
    end
  end

  // pin decode from the sequencer state
  assign prog_n_o    = !((state_q == ST_PROG) || (state_q == ST_WAIT_ILO));
  assign cclk_o      = (state_q != ST_CLK_LO);
  assign csel_n_o    = !port_selected(state_q);
  assign wr_n_o      = !(port_selected(state_q) || (state_q == ST_CS_OFF));
  assign cdata_oe_o  = port_selected(state_q);
  assign cdata_o     = data_q;
  assign active_o    = (state_q != ST_IDLE);
  assign ok_o        = ok_q;
  assign fail_o      = fail_q;
  assign fail_code_o = code_q;

  // R2: the program line is released only after init was seen low, or on failure
  a_r2_prog_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n_o) |-> (fail_o || $past(!init_n_i)));

  // R5: a byte is offered only while selected, target ready and not done
  a_r5_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (!csel_n_o && init_n_i && !done_i));

  // R5: data does not move across the capturing edge
  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cclk_o) && !csel_n_o) |-> $stable(cdata_o));

  // R6: a busy target holds off the next byte
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (CHECK_BUSY && tbusy_i && (state_q == ST_BUSY_WAIT)) |=> (cclk_o && !byte_ready_o));

  // R7: done before a byte ends the write phase
  a_r7_done_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CHECK) && done_i) |=> csel_n_o);

  // R8: init low before a byte aborts with the CRC code
  a_r8_crc_abort: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CHECK) && !empty_i && !done_i && !init_n_i) |=>
      (fail_o && (fail_code_o == 3'd3)));

  // R9: select is released before write on the normal path
  a_r9_cs_before_wr: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_n_o) && !fail_o) |-> $past(csel_n_o));

  // R10: a failure leaves the target port released
  a_r10_release_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> (csel_n_o && wr_n_o && prog_n_o && !cdata_oe_o && (fail_code_o != 3'd0)));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int DW         = 8,
  parameter int CNT_W      = 16,
  parameter int TW         = 32,
  parameter int PROG_CYC   = 64,
  parameter int INIT_TMO   = 100_000_000,
  parameter int SETTLE_CYC = 2_000_000,
  parameter int CCLK_LO    = 2,
  parameter int CCLK_HI    = 2,
  parameter int BUSY_TMO   = 1_000_000,
  parameter int DONE_TMO   = 40_000_000,
  parameter bit CHECK_BUSY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] total_bytes_i,
  input  logic [DW-1:0]    byte_data_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             prog_n_o,
  output logic             cclk_o,
  output logic             csel_n_o,
  output logic             wr_n_o,
  output logic [DW-1:0]    cdata_o,
  output logic             cdata_oe_o,
  input  logic             tgt_init_n_i,
  input  logic             tgt_busy_i,
  input  logic             tgt_done_i,
  output logic             active_o,
  output logic             ok_o,
  output logic             fail_o,
  output logic [2:0]       fail_code_o
);

  logic          tmr_clr, tmr_expired;
  logic [TW-1:0] tmr_limit;
  logic          cnt_load, cnt_dec, cnt_empty;

  cfgld_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .limit_i   (tmr_limit),
    .expired_o (tmr_expired)
  );

  cfgld_bytecnt #(.CNT_W(CNT_W)) u_bytecnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (total_bytes_i),
    .dec_i      (cnt_dec),
    .empty_o    (cnt_empty)
  );

  cfgld_seq #(
    .DW(DW), .TW(TW), .PROG_CYC(PROG_CYC), .INIT_TMO(INIT_TMO),
    .SETTLE_CYC(SETTLE_CYC), .CCLK_LO(CCLK_LO), .CCLK_HI(CCLK_HI),
    .BUSY_TMO(BUSY_TMO), .DONE_TMO(DONE_TMO), .CHECK_BUSY(CHECK_BUSY)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .byte_data_i  (byte_data_i),
    .byte_valid_i (byte_valid_i),
    .init_n_i     (tgt_init_n_i),
    .tbusy_i      (tgt_busy_i),
    .done_i       (tgt_done_i),
    .expired_i    (tmr_expired),
    .empty_i      (cnt_empty),
    .clr_o        (tmr_clr),
    .limit_o      (tmr_limit),
    .accept_o     (cnt_dec),
    .load_o       (cnt_load),
    .byte_ready_o (byte_ready_o),
    .prog_n_o     (prog_n_o),
    .cclk_o       (cclk_o),
    .csel_n_o     (csel_n_o),
    .wr_n_o       (wr_n_o),
    .cdata_o      (cdata_o),
    .cdata_oe_o   (cdata_oe_o),
    .active_o     (active_o),
    .ok_o         (ok_o),
    .fail_o       (fail_o),
    .fail_code_o  (fail_code_o)
  );

endmodule

// File: tb/test_cfg_loader.sv
module test_cfg_loader;

  localparam int P_PROG = 4, P_INIT = 20, P_SETTLE = 3, P_LO = 2, P_HI = 2;
  localparam int P_BUSY = 12, P_DONE = 30;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] total = '0;
  logic [7:0] bdata = '0;
  logic bvalid = 1'b0, bready;
  logic prog_n, cclk, cs_n, wr_n, oe, active, ok, fail;
  logic [7:0] cdata;
  logic [2:0] code;
  logic t_init_n = 1'b1, t_busy = 1'b0, t_done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_loader #(
    .PROG_CYC(P_PROG), .INIT_TMO(P_INIT), .SETTLE_CYC(P_SETTLE),
    .CCLK_LO(P_LO), .CCLK_HI(P_HI), .BUSY_TMO(P_BUSY), .DONE_TMO(P_DONE),
    .CHECK_BUSY(1'b1)
  ) i_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .total_bytes_i(total),
    .byte_data_i(bdata), .byte_valid_i(bvalid), .byte_ready_o(bready),
    .prog_n_o(prog_n), .cclk_o(cclk), .csel_n_o(cs_n), .wr_n_o(wr_n),
    .cdata_o(cdata), .cdata_oe_o(oe), .tgt_init_n_i(t_init_n),
    .tgt_busy_i(t_busy), .tgt_done_i(t_done), .active_o(active),
    .ok_o(ok), .fail_o(fail), .fail_code_o(code)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] stim(int i);
    return 8'((i * 53 + 29) ^ (i >> 1));
  endfunction

  // target model knobs
  bit m_init_lo = 1, m_init_hi = 1;
  int m_crc_at = 0, m_busy_hold = 0, m_done_at = 0;
  // target model state
  logic [7:0] cap [64];
  int ncap = 0, hi_cnt = 0, busy_cnt = 0;
  bit crc_flag = 0;
  logic t_prev_cclk = 1'b1;

  always @(negedge clk) begin
    if (!prog_n) begin
      ncap = 0; crc_flag = 0; hi_cnt = 0; busy_cnt = 0;
      t_busy <= 1'b0; t_done <= 1'b0;
      if (m_init_lo) t_init_n <= 1'b0;
    end else begin
      if (!t_init_n && !crc_flag) begin
        hi_cnt++;
        if (hi_cnt >= 5 && m_init_hi) t_init_n <= 1'b1;
      end
      if (!t_prev_cclk && cclk && !cs_n && !wr_n) begin
        if (ncap < 64) cap[ncap] = cdata;
        ncap++;
        if (ncap == m_crc_at) begin crc_flag = 1; t_init_n <= 1'b0; end
        if (m_busy_hold > 0) begin busy_cnt = m_busy_hold; t_busy <= 1'b1; end
        if (m_done_at > 0 && ncap >= m_done_at) t_done <= 1'b1;
      end else if (busy_cnt > 0) begin
        busy_cnt--;
        if (busy_cnt == 0) t_busy <= 1'b0;
      end
    end
    t_prev_cclk = cclk;
  end

  // host feeder
  int feed_n = 0, feed_idx = 0, cyc = 0;
  bit feed_gap = 0;
  always @(negedge clk) begin
    cyc++;
    if (start) feed_idx = 0;
    bvalid = (feed_idx < feed_n) && !(feed_gap && (cyc % 3 != 0));
    bdata  = stim(feed_idx);
    #2;
    if (bvalid && bready) feed_idx++;
  end

  // pin timing monitors
  int prog_run = 0, prog_w = 0, lo_run = 0, hi_run = 0, lo_min = 0, hi_min = 0;
  int cs_fall_cyc = 0, settle_w = -1, cs_rise_cyc = 0, wr_rise_cyc = 0, busy_viol = 0;
  bit seen_fall = 0;
  logic mp_cclk = 1'b1, mp_cs = 1'b1, mp_wr = 1'b1;
  always @(negedge clk) begin
    if (start) begin
      prog_run = 0; prog_w = 0; lo_min = 1000; hi_min = 1000; settle_w = -1;
      seen_fall = 0; busy_viol = 0; lo_run = 0; hi_run = 0;
    end
    if (!prog_n) prog_run++;
    else if (prog_run > 0) begin prog_w = prog_run; prog_run = 0; end
    if (mp_cs && !cs_n) cs_fall_cyc = cyc;
    if (!mp_cs && cs_n) cs_rise_cyc = cyc;
    if (!mp_wr && wr_n) wr_rise_cyc = cyc;
    if (!cs_n) begin
      if (mp_cclk && !cclk) begin
        if (!seen_fall) settle_w = cyc - cs_fall_cyc;
        else if (hi_run < hi_min) hi_min = hi_run;
        seen_fall = 1; lo_run = 0;
        if (t_busy) busy_viol++;
      end
      if (!mp_cclk && cclk && lo_run < lo_min) lo_min = lo_run;
      if (!cclk) lo_run++;
      if (cclk) begin
        if (!mp_cclk) hi_run = 0;
        hi_run++;
      end
    end
    mp_cclk = cclk; mp_cs = cs_n; mp_wr = wr_n;
  end

  task automatic run_load(int n, bit gap);
    @(negedge clk);
    feed_n = n; feed_gap = gap; total = 16'(n);
    #1 start = 1'b1;
    @(negedge clk);
    #1 start = 1'b0;
    for (int k = 0; k < 3000 && active; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic int cap_errors(int n);
    int e = 0;
    for (int i = 0; i < n && i < 64; i++) if (cap[i] !== stim(i)) e++;
    return e;
  endfunction

  task automatic check_released(string req);
    check(req, "pins released", int'({prog_n, cs_n, wr_n, oe}), int'(4'b1110));
  endtask

  task automatic t_reset;
    check("R1", "pins after reset", int'({prog_n, cclk, cs_n, wr_n, oe}), int'(5'b11110));
    check("R1", "status after reset", int'({active, ok, fail, bready}), 0);
  endtask

  task automatic t_normal;
    m_init_lo = 1; m_init_hi = 1; m_crc_at = 0; m_busy_hold = 0; m_done_at = 6;
    run_load(6, 0);
    check("R9", "ok after clean load", int'({ok, fail}), 2);
    check("R5", "bytes captured", ncap, 6);
    check("R5", "byte content errors", cap_errors(6), 0);
    check("R2", "prog pulse long enough", int'(prog_w >= P_PROG), 1);
    check("R4", "settle before first clock", int'(settle_w >= P_SETTLE), 1);
    check("R9", "cs rises before wr", int'(cs_rise_cyc < wr_rise_cyc), 1);
    check_released("R9");
  endtask

  task automatic t_throttled;
    m_init_lo = 1; m_init_hi = 1; m_crc_at = 0; m_busy_hold = 3; m_done_at = 10;
    run_load(10, 1);
    check("R6", "ok with busy and stalls", int'(ok), 1);
    check("R5", "bytes captured with gaps", ncap, 10);
    check("R5", "byte content errors with gaps", cap_errors(10), 0);
    check("R5", "cclk low width", int'(lo_min >= P_LO), 1);
    check("R5", "cclk high width", int'(hi_min >= P_HI), 1);
    check("R6", "clock falls while busy", busy_viol, 0);
  endtask

  task automatic t_init_assert_tmo;
    m_init_lo = 0; m_init_hi = 1; m_crc_at = 0; m_busy_hold = 0; m_done_at = 4;
    run_load(4, 0);
    check("R2", "fail code init-assert", int'({fail, code}), int'({1'b1, 3'd1}));
    check("R10", "no bytes clocked", ncap, 0);
    check_released("R10");
    m_init_lo = 1;
  endtask

  task automatic t_early_done;
    m_init_lo = 1; m_init_hi = 1; m_crc_at = 0; m_busy_hold = 0; m_done_at = 3;
    run_load(8, 0);
    check("R7", "ok on early done", int'({ok, fail}), 2);
    check("R7", "bytes clocked", ncap, 3);
    check("R7", "host bytes taken", feed_idx, 3);
  endtask

  task automatic t_crc;
    m_init_lo = 1; m_init_hi = 1; m_crc_at = 2; m_busy_hold = 0; m_done_at = 0;
    run_load(6, 0);
    check("R8", "fail code crc", int'({fail, code}), int'({1'b1, 3'd3}));
    check("R8", "bytes clocked before abort", ncap, 2);
    check("R8", "host bytes taken", feed_idx, 2);
    check_released("R10");
  endtask

  task automatic t_busy_stuck;
    m_init_lo = 1; m_init_hi = 1; m_crc_at = 0; m_busy_hold = 1000; m_done_at = 0;
    run_load(5, 0);
    check("R6", "fail code busy", int'({fail, code}), int'({1'b1, 3'd4}));
    check("R6", "bytes clocked", ncap, 1);
    check_released("R10");
  endtask

  task automatic t_done_tmo;
    m_init_lo = 1; m_init_hi = 1; m_crc_at = 0; m_busy_hold = 0; m_done_at = 0;
    run_load(4, 0);
    check("R9", "fail code done", int'({fail, code}), int'({1'b1, 3'd5}));
    check("R9", "all bytes clocked", ncap, 4);
  endtask

  task automatic t_init_release_tmo;
    m_init_lo = 1; m_init_hi = 0; m_crc_at = 0; m_busy_hold = 0; m_done_at = 0;
    run_load(4, 0);
    check("R3", "fail code init-release", int'({fail, code}), int'({1'b1, 3'd2}));
    check("R3", "no bytes clocked", ncap, 0);
    m_init_hi = 1;
  endtask

  task automatic t_restart;
    m_init_lo = 1; m_init_hi = 1; m_crc_at = 0; m_busy_hold = 2; m_done_at = 5;
    run_load(5, 1);
    check("R10", "restart after failure ok", int'({ok, fail, code}), int'({2'b10, 3'd0}));
    check("R10", "restart byte content", cap_errors(5), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_normal();
    t_throttled();
    t_init_assert_tmo();
    t_early_done();
    t_crc();
    t_busy_stuck();
    t_done_tmo();
    t_init_release_tmo();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule